// File: doc/BRIEF.md
# SHA-1 Block Compression Engine with Register Access

This block hashes messages with SHA-1, one 512-bit block at a time, under software control over a simple 32-bit register bus. Software writes the sixteen message words of a block into a write-only data window, then writes the control word with the start bit set. A busy flag stays high while the engine runs the 80 compression rounds, one per clock. When the flag clears, the five 32-bit words of the chaining state are read back as the digest.

A continuation bit in the control word picks the starting state of each block. When the bit is set, the block continues from the digest left by the previous block, so a long message is hashed by feeding its blocks in order. When the bit is clear, the state restarts from the standard SHA-1 initial values. Software must supply the padding and the length field in the final block. A separate soft-reset register holds the engine idle for as long as it holds 1.

Top module: `sha1_mmio_engine`

## Requirements
- R1: After reset the control word reads 0 and the five result words read 67452301, EFCDAB89, 98BADCFE, 10325476, C3D2E1F0 (hex, at 0x20, 0x24, 0x28, 0x2C, 0x30).
- R2: Writing 0x00 with bit 1 (start) set and bit 3 (continue) clear hashes the loaded block from the initial values. The one-block message "abc" gives A9993E36 4706816A BA3E2571 7850C26C 9CD0D89D.
- R3: Writing 0x00 with bits 1 and 3 both set hashes the loaded block from the current result words, so successive blocks chain.
- R4: Bit 0 of 0x00 (busy) reads 1 for exactly 81 clock cycles, counted from the clock edge that takes the start write.
- R5: Bit 1 of 0x00 always reads 0. Bit 3 reads back the last value written to it.
- R6: A start write while busy is 1 is ignored: the run length and the digest are unchanged.
- R7: Writes to the data window while busy is 1 are ignored. The digest equals that of the block loaded before the start.
- R8: Writing 1 to bit 0 of 0x04 stops any run, so busy reads 0 and the result words return to the initial values one cycle later. Start writes are ignored until 0 is written to 0x04. Bit 0 of 0x04 reads back its value.
- R9: Offsets 0x10 (byte order) and 0x80 (bus-master mode) read 0, which selects default byte order and register-fed operation. Unmapped offsets and the write-only data window read 0.
- R10: The word written at 0x40+4i is big-endian message word i (i = 0..15). The result word at 0x20+4j is chaining word j (j = 0..4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
The bench checks the digest of "abc" against its published value and checks many more blocks against an arithmetic SHA-1 model, both alone and chained. A wrong round constant, boolean function or schedule tap would corrupt every one of these digests. Busy is timed to the cycle, so an off-by-one in the round counter shows up as 80 or 82 cycles. The bench also sends start and data writes in the middle of a run. A design that accepted them would restart the count or corrupt the in-place schedule. Finally, soft reset is asserted during a run: a design that kept running, kept the old state or took a start while held would show busy, a stale digest or a spurious run.

// File: rtl/sha1_eng_pkg.sv
package sha1_eng_pkg;
   localparam int WORD_W    = 32;
   localparam int NUM_H     = 5;
   localparam int BLK_WORDS = 16;
   localparam int ROUNDS    = 80;
   localparam int RND_W     = $clog2(ROUNDS);

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [NUM_H-1:0][WORD_W-1:0] state_t;

   function automatic word_t iv_word(input int j);
      case (j)
         0:       return 32'h67452301;
         1:       return 32'hEFCDAB89;
         2:       return 32'h98BADCFE;
         3:       return 32'h10325476;
         default: return 32'hC3D2E1F0;
      endcase
   endfunction

   function automatic state_t iv_state();
      state_t s;
      for (int j = 0; j < NUM_H; j++) s[j] = iv_word(j);
      return s;
   endfunction

   function automatic word_t rotl(input word_t x, input int n);
      return (x << n) | (x >> (WORD_W - n));
   endfunction

   function automatic word_t round_k(input int t);
      if (t < 20)      return 32'h5A827999;
      else if (t < 40) return 32'h6ED9EBA1;
      else if (t < 60) return 32'h8F1BBCDC;
      else             return 32'hCA62C1D6;
   endfunction

   function automatic word_t round_f(input int t, input word_t b, input word_t c, input word_t d);
      if (t < 20)                return (b & c) | (~b & d);
      else if (t >= 40 && t < 60) return (b & c) | (b & d) | (c & d);
      else                       return b ^ c ^ d;
   endfunction
endpackage

// File: rtl/sha1_msg_sched.sv
module sha1_msg_sched
   import sha1_eng_pkg::*;
#(
   parameter int WORDS = BLK_WORDS
) (
   input  logic                     clk,
   input  logic                     wr_i,
   input  logic [$clog2(WORDS)-1:0] idx_i,
   input  word_t                    data_i,
   input  logic                     shift_i,
   output word_t                    w_o
);
   localparam int IDX_W = $clog2(WORDS);

   word_t w_q [WORDS];
   word_t w_new;

   initial begin
      assert (WORDS == 16) else $error("sha1_msg_sched: schedule needs 16 words");
   end

   assign w_new = rotl(w_q[13] ^ w_q[8] ^ w_q[2] ^ w_q[0], 1);
   assign w_o   = w_q[0];

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      always_ff @(posedge clk) begin
         if (shift_i)
            w_q[i] <= (i == WORDS-1) ? w_new : w_q[(i+1) % WORDS];
         else if (wr_i && idx_i == IDX_W'(i))
            w_q[i] <= data_i;
      end
   end

   // R7: a bus load never lands while the schedule is rolling
   p_no_load_in_run_r7: assert property (@(posedge clk) !(wr_i && shift_i));
endmodule

// File: rtl/sha1_ctrl.sv
module sha1_ctrl
   import sha1_eng_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst_i,
   input  logic             go_i,
   output logic             busy_o,
   output logic             start_o,
   output logic             run_o,
   output logic             fin_o,
   output logic [RND_W-1:0] round_o
);
   typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_e;
   st_e              st_q;
   logic [RND_W-1:0] cnt_q;

   assign busy_o  = (st_q != S_IDLE);
   assign start_o = go_i && (st_q == S_IDLE) && !srst_i;
   assign run_o   = (st_q == S_RUN) && !srst_i;
   assign fin_o   = (st_q == S_FIN) && !srst_i;
   assign round_o = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= S_IDLE;
         cnt_q <= '0;
      end else if (srst_i) begin
         st_q  <= S_IDLE;
         cnt_q <= '0;
      end else begin
         case (st_q)
            S_IDLE: if (start_o) begin
               st_q  <= S_RUN;
               cnt_q <= '0;
            end
            S_RUN: begin
               if (cnt_q == RND_W'(ROUNDS-1)) st_q <= S_FIN;
               else                          cnt_q <= cnt_q + 1'b1;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   // R4: a run always begins at round zero
   p_start_round0_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (cnt_q == '0));
   // R4: busy does not drop before the final accumulate cycle
   p_no_early_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && !srst_i) |=> busy_o);
   // R8: soft reset forces idle on the next edge
   p_srst_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      srst_i |=> !busy_o);
   // R6: a start request while running does not restart the count
   p_go_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (go_i && run_o && cnt_q != '0 && cnt_q != RND_W'(ROUNDS-1)) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/sha1_round_core.sv
module sha1_round_core
   import sha1_eng_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_i,
   input  logic             start_i,
   input  logic             cont_i,
   input  logic             run_i,
   input  logic             fin_i,
   input  logic [RND_W-1:0] round_i,
   input  word_t            w_i,
   output state_t           h_o
);
   state_t h_q;
   state_t v_q;
   word_t  tmp;

   assign tmp = rotl(v_q[0], 5)
              + round_f(int'(round_i), v_q[1], v_q[2], v_q[3])
              + v_q[4] + round_k(int'(round_i)) + w_i;
   assign h_o = h_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_q <= iv_state();
         v_q <= '0;
      end else if (init_i) begin
         h_q <= iv_state();
      end else if (start_i) begin
         if (cont_i) begin
            v_q <= h_q;
         end else begin
            h_q <= iv_state();
            v_q <= iv_state();
         end
      end else if (run_i) begin
         v_q[0] <= tmp;
         v_q[1] <= v_q[0];
         v_q[2] <= rotl(v_q[1], 30);
         v_q[3] <= v_q[2];
         v_q[4] <= v_q[3];
      end else if (fin_i) begin
         for (int j = 0; j < NUM_H; j++) h_q[j] <= h_q[j] + v_q[j];
      end
   end

   // R3: the chaining state holds still during the rounds
   p_chain_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !init_i) |=> $stable(h_q));
   // R8: soft reset returns the chaining state to the initial values
   p_init_iv_r8: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> (h_q == iv_state()));
endmodule

// File: rtl/sha1_mmio_engine.sv
module sha1_mmio_engine
   import sha1_eng_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata
);
   localparam int WA_W     = ADDR_W - 2;
   localparam int CTRL_WI  = 0;
   localparam int SRST_WI  = 1;
   localparam int RES_WI   = 8;
   localparam int DATA_WI  = 16;
   localparam int IDX_W    = $clog2(BLK_WORDS);
   localparam int BUSY_BIT = 0;
   localparam int GO_BIT   = 1;
   localparam int CONT_BIT = 3;

   initial begin
      assert (ADDR_W >= 8) else $error("sha1_mmio_engine: ADDR_W must reach offset 0x80");
   end

   logic [WA_W-1:0]  wa;
   logic             srst_q, cont_q;
   logic             busy, start, run, fin, go_wr, data_wr, in_data;
   logic [RND_W-1:0] round;
   word_t            w_cur;
   state_t           h;

   assign wa      = bus_addr[ADDR_W-1:2];
   assign in_data = (wa >= WA_W'(DATA_WI)) && (wa < WA_W'(DATA_WI + BLK_WORDS));
   assign go_wr   = bus_we && (wa == WA_W'(CTRL_WI)) && bus_wdata[GO_BIT];
   assign data_wr = bus_we && in_data && !busy && !srst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         srst_q <= 1'b0;
         cont_q <= 1'b0;
      end else if (bus_we) begin
         if (wa == WA_W'(SRST_WI)) srst_q <= bus_wdata[0];
         if (wa == WA_W'(CTRL_WI)) cont_q <= bus_wdata[CONT_BIT];
      end
   end

   sha1_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .srst_i  (srst_q),
      .go_i    (go_wr),
      .busy_o  (busy),
      .start_o (start),
      .run_o   (run),
      .fin_o   (fin),
      .round_o (round)
   );

   sha1_msg_sched #(.WORDS(BLK_WORDS)) u_sched (
      .clk     (clk),
      .wr_i    (data_wr),
      .idx_i   (bus_addr[IDX_W+1:2]),
      .data_i  (bus_wdata),
      .shift_i (run),
      .w_o     (w_cur)
   );

   sha1_round_core u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .init_i  (srst_q),
      .start_i (start),
      .cont_i  (bus_wdata[CONT_BIT]),
      .run_i   (run),
      .fin_i   (fin),
      .round_i (round),
      .w_i     (w_cur),
      .h_o     (h)
   );

   word_t res_mux [NUM_H];
   for (genvar j = 0; j < NUM_H; j++) begin : g_res
      assign res_mux[j] = h[j];
   end

   always_comb begin
      bus_rdata = '0;
      if (wa == WA_W'(CTRL_WI)) begin
         bus_rdata[BUSY_BIT] = busy && !srst_q;
         bus_rdata[CONT_BIT] = cont_q;
      end else if (wa == WA_W'(SRST_WI)) begin
         bus_rdata[0] = srst_q;
      end else begin
         for (int j = 0; j < NUM_H; j++)
            if (wa == WA_W'(RES_WI + j)) bus_rdata = res_mux[j];
      end
   end

   // R8: busy is never reported while soft reset is held
   p_busy_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      srst_q |-> !bus_rdata[BUSY_BIT] || wa != WA_W'(CTRL_WI));
   // R5: the start bit never reads back as 1
   p_go_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wa == WA_W'(CTRL_WI)) |-> !bus_rdata[GO_BIT]);
endmodule

// File: tb/sha1_mmio_engine_bench.sv
module sha1_mmio_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int checks = 0, fails = 0, cyc = 0;
   logic [31:0] blk [16];
   logic [31:0] hm [5];
   logic [31:0] rd;
   logic [31:0] seed = 32'h1234_5678;

   sha1_mmio_engine u_sha1_mmio_engine (.*);

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   function automatic logic [31:0] rl(input logic [31:0] x, input int n);
      return (x << n) | (x >> (32 - n));
   endfunction

   task automatic model(input bit cont);
      logic [31:0] w [80];
      logic [31:0] a, b, c, d, e, f, k, t;
      if (!cont) begin
         hm[0] = 32'h67452301; hm[1] = 32'hEFCDAB89; hm[2] = 32'h98BADCFE;
         hm[3] = 32'h10325476; hm[4] = 32'hC3D2E1F0;
      end
      for (int i = 0; i < 80; i++)
         w[i] = (i < 16) ? blk[i] : rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
      a = hm[0]; b = hm[1]; c = hm[2]; d = hm[3]; e = hm[4];
      for (int i = 0; i < 80; i++) begin
         if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
         else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
         else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
         else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
         t = rl(a, 5) + f + e + k + w[i];
         e = d; d = c; c = rl(b, 30); b = a; a = t;
      end
      hm[0] += a; hm[1] += b; hm[2] += c; hm[3] += d; hm[4] += e;
   endtask

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bw(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic br(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic load_blk();
      for (int i = 0; i < 16; i++) bw(8'h40 + 8'(4*i), blk[i]);
   endtask

   task automatic run_blk(input bit cont, input string req);
      int t0;
      bw(8'h00, cont ? 32'hA : 32'h2);
      t0 = cyc;
      do br(8'h00, rd); while (rd[0]);
      check(cyc - t0 == 81, "R4", 32'(cyc - t0), 32'd81);
      model(cont);
      for (int j = 0; j < 5; j++) begin
         br(8'h20 + 8'(4*j), rd);
         check(rd == hm[j], req, rd, hm[j]);
      end
   endtask

   task automatic abc_blk();
      for (int i = 0; i < 16; i++) blk[i] = '0;
      blk[0] = 32'h61626380; blk[15] = 32'h18;
   endtask

   task automatic rnd_blk();
      for (int i = 0; i < 16; i++) begin
         seed = seed * 32'd1664525 + 32'd1013904223;
         blk[i] = seed;
      end
   endtask

   initial begin
      int t0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R1 reset state
      br(8'h00, rd); check(rd == 0, "R1", rd, 0);
      br(8'h20, rd); check(rd == 32'h67452301, "R1", rd, 32'h67452301);
      br(8'h30, rd); check(rd == 32'hC3D2E1F0, "R1", rd, 32'hC3D2E1F0);
      // R9 fixed-zero and unmapped offsets
      br(8'h10, rd); check(rd == 0, "R9", rd, 0);
      br(8'h80, rd); check(rd == 0, "R9", rd, 0);
      br(8'h34, rd); check(rd == 0, "R9", rd, 0);

      // R2 / R10 known answer for "abc"
      abc_blk(); load_blk();
      br(8'h40, rd); check(rd == 0, "R9", rd, 0);
      run_blk(1'b0, "R2");
      br(8'h20, rd); check(rd == 32'hA9993E36, "R10", rd, 32'hA9993E36);
      br(8'h30, rd); check(rd == 32'h9CD0D89D, "R10", rd, 32'h9CD0D89D);

      // R5 start bit reads 0, continue bit persists
      bw(8'h00, 32'h8); br(8'h00, rd); check(rd == 32'h8, "R5", rd, 32'h8);
      bw(8'h00, 32'h0); br(8'h00, rd); check(rd == 32'h0, "R5", rd, 32'h0);

      // R3 chained sweep over many blocks
      rnd_blk(); load_blk(); run_blk(1'b0, "R3");
      for (int n = 0; n < 12; n++) begin
         rnd_blk(); load_blk(); run_blk(1'b1, "R3");
      end
      // R2 restart from initial values after a chain
      abc_blk(); load_blk(); run_blk(1'b0, "R2");

      // R6 / R7 start and data writes during a run
      abc_blk(); load_blk();
      bw(8'h00, 32'h2);
      t0 = cyc;
      repeat (20) @(negedge clk);
      bw(8'h00, 32'h2);
      bw(8'h44, 32'hDEADBEEF);
      bw(8'h7C, 32'h0BADF00D);
      do br(8'h00, rd); while (rd[0]);
      check(cyc - t0 == 81, "R6", 32'(cyc - t0), 32'd81);
      br(8'h20, rd); check(rd == 32'hA9993E36, "R7", rd, 32'hA9993E36);
      br(8'h2C, rd); check(rd == 32'h7850C26C, "R7", rd, 32'h7850C26C);

      // R8 soft reset mid-run
      abc_blk(); load_blk();
      bw(8'h00, 32'h2);
      repeat (10) @(negedge clk);
      bw(8'h04, 32'h1);
      br(8'h00, rd); check(rd[0] == 1'b0, "R8", 32'(rd[0]), 0);
      br(8'h04, rd); check(rd == 1, "R8", rd, 1);
      br(8'h24, rd); check(rd == 32'hEFCDAB89, "R8", rd, 32'hEFCDAB89);
      bw(8'h00, 32'h2);
      repeat (3) @(negedge clk);
      br(8'h00, rd); check(rd[0] == 1'b0, "R8", 32'(rd[0]), 0);
      br(8'h20, rd); check(rd == 32'h67452301, "R8", rd, 32'h67452301);
      bw(8'h04, 32'h0);
      br(8'h04, rd); check(rd == 0, "R8", rd, 0);
      abc_blk(); load_blk(); run_blk(1'b0, "R8");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule